// File: doc/BRIEF.md
# Instruction Fetch Stage with Stall

This block is the front stage of a 32-bit, five-stage in-order RISC pipeline. It owns the program counter, picks the next fetch address every cycle, and reads the instruction at the current address from a read-only program store held inside the block. The address and its instruction leave the block together in the same cycle, and the block also presents the sequential successor address (PC+4) for use by later stages.

Each cycle one of three things happens to the program counter. A stall holds it. Otherwise, a branch request from a later stage loads the target that stage supplies. Otherwise, the counter steps to the next word. The branch decision is made downstream, so it reaches the fetch stage several cycles after the branch itself was fetched. Squashing the instructions fetched in the meantime is the job of the pipeline registers that follow this block.

The fetched instruction stream uses no valid/ready handshake. Back-pressure comes only from the stall pin, which is a plain control input. While it is high, the same address and instruction stay on the outputs.

Top module: `instr_fetch_stage`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 at the next rising clock edge.
- R2: With stall and branch request both low, the program counter increases by 4 at each rising edge, wrapping modulo 2^32.
- R3: With stall low and branch request high, the program counter loads the branch target input at the next rising edge.
- R4: With stall high, the program counter keeps its value at the next rising edge, whatever the branch request and target are.
- R5: The instruction output is a combinational function of the current program counter, so it changes in the same cycle as the program counter.
- R6: The store is indexed by program counter bits [15:2] (16384 words). Bits [1:0] and bits [31:16] have no effect on the instruction read.
- R7: The successor output equals the current program counter plus 4, modulo 2^32.
- R8: The store word at index i equals (i * 0x9E3779B1 + 0x13572468) modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze the program counter; has priority over the branch request |
| br_take_i | input | 1 | Load the branch target instead of stepping sequentially |
| br_target_i | input | 32 | Branch target address from a later stage |
| pc_o | output | 32 | Current fetch address |
| instr_o | output | 32 | Instruction at the current fetch address |
| pc_plus4_o | output | 32 | Current fetch address plus 4 |

## Verification
On every cycle, the assertions check how the program counter moves: it clears after reset, holds under stall, loads the target on a branch, and steps by four otherwise. Only the bench's scenarios can show that the correct instruction words appear. This covers the store contents, aliasing when the upper or low address bits differ, and the same-cycle pairing of address and instruction. The bench also exercises a stall that coincides with a branch request, and a wrap of the address past the top of the 32-bit space.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] ROM_MUL = 32'h9E37_79B1;
  localparam logic [XLEN-1:0] ROM_ADD = 32'h1357_2468;

  // Program store contents, computed per index instead of tabulated.
  function automatic logic [XLEN-1:0] rom_word(input logic [XLEN-1:0] idx);
    return idx * ROM_MUL + ROM_ADD;
  endfunction
endpackage

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc_d,
  output logic [XLEN-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_d;
  end

  p_reset_value_r1: assert property (@(posedge clk) rst |=> pc_q == RESET_PC)
    else $error("R1: program counter not cleared by reset");
endmodule

// File: rtl/fetch_next_pc.sv
module fetch_next_pc #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic            stall,
  input  logic            take,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc_next,
  output logic [XLEN-1:0] pc_seq
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  assign pc_seq = pc + STEP_V;

  // Priority: stall, then branch, then sequential step.
  always_comb begin
    if (stall)     pc_next = pc;
    else if (take) pc_next = target;
    else           pc_next = pc_seq;
  end
endmodule

// File: rtl/fetch_rom.sv
module fetch_rom #(
  parameter int XLEN = 32,
  parameter int AW   = 14
) (
  input  logic [AW-1:0]   idx,
  output logic [XLEN-1:0] word
);
  localparam int PAD = XLEN - AW;

  always_comb word = fetch_pkg::rom_word({{PAD{1'b0}}, idx});
endmodule

// File: rtl/instr_fetch_stage.sv
module instr_fetch_stage #(
  parameter int ROM_AW = 14
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stall_i,
  input  logic        br_take_i,
  input  logic [31:0] br_target_i,
  output logic [31:0] pc_o,
  output logic [31:0] instr_o,
  output logic [31:0] pc_plus4_o
);
  localparam int XLEN = fetch_pkg::XLEN;
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + ROM_AW - 1;

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] pc_seq;

  fetch_pc_reg #(.XLEN(XLEN)) u_pc (
    .clk(clk), .rst(rst), .pc_d(pc_d), .pc_q(pc_q)
  );

  fetch_next_pc #(.XLEN(XLEN), .STEP(4)) u_npc (
    .pc(pc_q), .stall(stall_i), .take(br_take_i), .target(br_target_i),
    .pc_next(pc_d), .pc_seq(pc_seq)
  );

  fetch_rom #(.XLEN(XLEN), .AW(ROM_AW)) u_rom (
    .idx(pc_q[IDX_HI:IDX_LO]), .word(instr_o)
  );

  assign pc_o       = pc_q;
  assign pc_plus4_o = pc_seq;

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !br_take_i) |=> pc_o == $past(pc_o) + 32'd4)
    else $error("R2: sequential step wrong");

  p_branch_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && br_take_i) |=> pc_o == $past(br_target_i))
    else $error("R3: branch target not loaded");

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> $stable(pc_o))
    else $error("R4: program counter moved under stall");
endmodule

// File: tb/tb_instr_fetch_stage.sv
module tb_instr_fetch_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall_i = 1'b0;
  logic        br_take_i = 1'b0;
  logic [31:0] br_target_i = '0;
  logic [31:0] pc_o, instr_o, pc_plus4_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_pc;       // reference program counter
  logic        m_valid = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  instr_fetch_stage dut (
    .clk(clk), .rst(rst), .stall_i(stall_i), .br_take_i(br_take_i),
    .br_target_i(br_target_i), .pc_o(pc_o), .instr_o(instr_o),
    .pc_plus4_o(pc_plus4_o)
  );

  function automatic logic [31:0] exp_word(input logic [31:0] addr);
    logic [31:0] i;
    i = {18'd0, addr[15:2]};
    return i * 32'h9E3779B1 + 32'h13572468;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare all outputs to the model, mid-cycle.
  task automatic compare();
    chk("R1/R2/R3/R4 pc", pc_o, m_pc);
    chk("R5/R6/R8 instr", instr_o, exp_word(m_pc));
    chk("R7 pc_plus4", pc_plus4_o, m_pc + 32'd4);
  endtask

  // Apply inputs for one cycle: drive at negedge, model updates at posedge.
  task automatic step(input logic r, input logic s, input logic b, input logic [31:0] t);
    rst = r; stall_i = s; br_take_i = b; br_target_i = t;
    @(posedge clk);
    if (r)      m_pc = 32'd0;
    else if (s) m_pc = m_pc;
    else if (b) m_pc = t;
    else        m_pc = m_pc + 32'd4;
    m_valid = 1'b1;
    @(negedge clk);
    compare();
  endtask

  logic [31:0] saved;

  initial begin
    @(negedge clk);
    step(1, 0, 0, 32'h0);
    chk("R1 reset pc", pc_o, 32'h0);
    // R1 reset while stalled and branching still clears
    step(1, 1, 1, 32'h40);
    chk("R1 reset over stall", pc_o, 32'h0);
    // R2 sequential run
    for (int k = 0; k < 8; k++) step(0, 0, 0, 32'h0);
    chk("R2 after 8 steps", pc_o, 32'h20);
    // R3 branch
    step(0, 0, 1, 32'h0000_0100);
    chk("R3 branch load", pc_o, 32'h100);
    // R4 stall with branch request present
    step(0, 1, 1, 32'h0000_0800);
    chk("R4 stall beats branch", pc_o, 32'h100);
    step(0, 1, 0, 32'h0);
    chk("R4 stall hold", pc_o, 32'h100);
    // R6 aliasing: upper bits ignored
    step(0, 0, 1, 32'h0000_0010);
    saved = instr_o;
    step(0, 0, 1, 32'hABCD_0010);
    chk("R6 upper bits ignored", instr_o, saved);
    // R6 low bits ignored
    step(0, 0, 1, 32'h0000_0013);
    chk("R6 low bits ignored", instr_o, saved);
    // R8 specific index 4
    chk("R8 word at index 4", instr_o, 32'h13572468 + 32'd4 * 32'h9E3779B1);
    // R2/R7 wrap at top of address space
    step(0, 0, 1, 32'hFFFF_FFFC);
    chk("R7 plus4 wraps", pc_plus4_o, 32'h0);
    step(0, 0, 0, 32'h0);
    chk("R2 pc wraps", pc_o, 32'h0);
    // R5 same-cycle instruction on a long sequential walk through the store
    step(0, 0, 1, 32'h0000_FFF0);
    for (int k = 0; k < 12; k++) step(0, 0, 0, 32'h0);
    // Mixed pseudo-random traffic
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[0] & rv[1] & rv[2] & rv[3], rv[4] & rv[5], rv[6], $urandom);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule